// File: doc/BRIEF.md
# DE-Only Sync Regenerator

This block rebuilds line and frame synchronisation for a pixel stream that carries a data-enable (DE) qualifier and no sync pulses. Each pixel clocked with DE low is treated as an empty pixel. The block counts how many empty pixels arrive in a row. When that run becomes long enough to be a horizontal blanking gap, it emits a line sync pulse. When the run becomes long enough to be a vertical blanking gap, it emits a frame sync pulse. Logic further down the stream can then order lines and frames as if the source had sent real syncs.

The two run lengths that mark a line gap and a frame gap can be programmed at run time. A write is accepted only if the line threshold is above 1 and below the frame threshold. A write that breaks this rule is dropped, the previous thresholds stay in force, and an error strobe is raised. The width of each pulse is set by a parameter, so a pulse can last one cycle or be stretched over several.

Top module: `de_sync_regen`

## Requirements
- R1: `hsync_o` goes high in the cycle after the clock edge that samples the N-th consecutive pixel with `de_i` low, where N is the line threshold on `hgap_o`.
- R2: `vsync_o` goes high in the cycle after the clock edge that samples the M-th consecutive pixel with `de_i` low, where M is the frame threshold on `vgap_o`.
- R3: Any pixel sampled with `de_i` high clears the run count, so the empty pixels on both sides of it are never summed. No sync rises in the cycle after a DE-high pixel.
- R4: The run counter stops at 2^CNT_W-1 and does not wrap. Each sync fires at most once per gap, even when a gap is longer than the counter range or a threshold equals 2^CNT_W-1.
- R5: A line pulse stays high for HS_PULSE cycles (default 2) and a frame pulse for VS_PULSE cycles (default 3). A new firing while a pulse is still high starts its width again.
- R6: A write (`cfg_wr_i` high) with 1 < `cfg_hgap_i` < `cfg_vgap_i` is accepted. The new values appear on `hgap_o`/`vgap_o` and govern firing from the next cycle on.
- R7: A write that breaks the rule in R6 leaves both thresholds unchanged and raises `cfg_err_o` for exactly the next cycle. `cfg_err_o` is low at all other times.
- R8: After reset both syncs and `cfg_err_o` are low, and the thresholds are DEF_HGAP (4) and DEF_VGAP (40).
- R9: A write in the same cycle as a firing pixel does not affect that firing. The comparison uses the thresholds held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| de_i | input | 1 | Data enable of the current pixel (low = empty pixel) |
| cfg_wr_i | input | 1 | Threshold write strobe |
| cfg_hgap_i | input | CNT_W | Proposed line-gap threshold |
| cfg_vgap_i | input | CNT_W | Proposed frame-gap threshold |
| hsync_o | output | 1 | Regenerated line sync, active high |
| vsync_o | output | 1 | Regenerated frame sync, active high |
| cfg_err_o | output | 1 | One-cycle strobe for a rejected write |
| hgap_o | output | CNT_W | Line threshold in force |
| vgap_o | output | CNT_W | Frame threshold in force |

## Verification
Two events can fall in the same cycle: a threshold write and the pixel that reaches the old threshold. The bench provokes this by issuing a write that raises the line threshold on the exact edge that samples the fourth empty pixel. It expects the line pulse to fire anyway, and it expects the new value on `hgap_o` one cycle later. The same overlap also occurs between the two pulses: with the frame threshold set one above the line threshold, the stretched line pulse is still high when the frame pulse fires. The cycle-by-cycle model in the bench checks that each output keeps its own width.

// File: rtl/sr_pkg.sv
package sr_pkg;

    typedef enum logic [1:0] {
        WR_NONE   = 2'd0,
        WR_TAKE   = 2'd1,
        WR_REJECT = 2'd2
    } wr_verdict_e;

endpackage

// File: rtl/sr_gap_counter.sv
module sr_gap_counter #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             de_i,
    output logic             adv_o,
    output logic [CNT_W-1:0] nxt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    // The count only advances on an empty pixel and only while below the ceiling.
    always_comb begin
        st_d  = st_q;
        adv_o = 1'b0;
        nxt_o = st_q.cnt + 1'b1;
        if (de_i) begin
            st_d.cnt = '0;
        end else if (st_q.cnt != CNT_MAX) begin
            adv_o    = 1'b1;
            st_d.cnt = nxt_o;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/sr_thresh_regs.sv
module sr_thresh_regs
    import sr_pkg::*;
#(
    parameter int CNT_W    = 12,
    parameter int DEF_HGAP = 4,
    parameter int DEF_VGAP = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] hgap_i,
    input  logic [CNT_W-1:0] vgap_i,
    output logic [CNT_W-1:0] hgap_o,
    output logic [CNT_W-1:0] vgap_o,
    output logic             err_o
);
    localparam logic [CNT_W-1:0] RST_H = CNT_W'(DEF_HGAP);
    localparam logic [CNT_W-1:0] RST_V = CNT_W'(DEF_VGAP);
    localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] hgap;
        logic [CNT_W-1:0] vgap;
        logic             err;
    } thr_state_t;

    thr_state_t  st_d, st_q;
    wr_verdict_e verdict;

    always_comb begin
        verdict = WR_NONE;
        if (wr_i) begin
            if ((hgap_i > ONE) && (hgap_i < vgap_i)) verdict = WR_TAKE;
            else                                     verdict = WR_REJECT;
        end
    end

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        case (verdict)
            WR_TAKE: begin
                st_d.hgap = hgap_i;
                st_d.vgap = vgap_i;
            end
            WR_REJECT: st_d.err = 1'b1;
            default:   ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.hgap <= RST_H;
            st_q.vgap <= RST_V;
            st_q.err  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hgap_o = st_q.hgap;
    assign vgap_o = st_q.vgap;
    assign err_o  = st_q.err;

endmodule

// File: rtl/sr_sync_pulse.sv
module sr_sync_pulse #(
    parameter int CNT_W = 12,
    parameter int PULSE = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv_i,
    input  logic [CNT_W-1:0] nxt_i,
    input  logic [CNT_W-1:0] thr_i,
    output logic             pulse_o
);
    localparam int REM_W = (PULSE < 2) ? 1 : $clog2(PULSE + 1);
    localparam logic [REM_W-1:0] REM_LOAD = REM_W'(PULSE);

    typedef struct packed {
        logic [REM_W-1:0] rem;
    } pul_state_t;

    pul_state_t st_d, st_q;
    logic       fire;

    // Equality on an advancing count hits at most once per gap.
    always_comb begin
        fire = adv_i && (nxt_i == thr_i);
        st_d = st_q;
        if (fire)                 st_d.rem = REM_LOAD;
        else if (st_q.rem != '0)  st_d.rem = st_q.rem - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pulse_o = (st_q.rem != '0);

endmodule

// File: rtl/de_sync_regen.sv
module de_sync_regen #(
    parameter int CNT_W    = 12,
    parameter int HS_PULSE = 2,
    parameter int VS_PULSE = 3,
    parameter int DEF_HGAP = 4,
    parameter int DEF_VGAP = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             de_i,
    input  logic             cfg_wr_i,
    input  logic [CNT_W-1:0] cfg_hgap_i,
    input  logic [CNT_W-1:0] cfg_vgap_i,
    output logic             hsync_o,
    output logic             vsync_o,
    output logic             cfg_err_o,
    output logic [CNT_W-1:0] hgap_o,
    output logic [CNT_W-1:0] vgap_o
);
    logic             run_adv;
    logic [CNT_W-1:0] run_nxt;

    sr_gap_counter #(.CNT_W(CNT_W)) gap_cnt_i (
        .clk   (clk),
        .rst_n (rst_n),
        .de_i  (de_i),
        .adv_o (run_adv),
        .nxt_o (run_nxt)
    );

    sr_thresh_regs #(
        .CNT_W    (CNT_W),
        .DEF_HGAP (DEF_HGAP),
        .DEF_VGAP (DEF_VGAP)
    ) thr_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (cfg_wr_i),
        .hgap_i (cfg_hgap_i),
        .vgap_i (cfg_vgap_i),
        .hgap_o (hgap_o),
        .vgap_o (vgap_o),
        .err_o  (cfg_err_o)
    );

    sr_sync_pulse #(.CNT_W(CNT_W), .PULSE(HS_PULSE)) hs_gen_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv_i   (run_adv),
        .nxt_i   (run_nxt),
        .thr_i   (hgap_o),
        .pulse_o (hsync_o)
    );

    sr_sync_pulse #(.CNT_W(CNT_W), .PULSE(VS_PULSE)) vs_gen_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv_i   (run_adv),
        .nxt_i   (run_nxt),
        .thr_i   (vgap_o),
        .pulse_o (vsync_o)
    );

endmodule

// File: rtl/de_sync_regen_chk.sv
module de_sync_regen_chk #(
    parameter int CNT_W    = 12,
    parameter int HS_PULSE = 2,
    parameter int VS_PULSE = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             de_i,
    input logic             cfg_wr_i,
    input logic [CNT_W-1:0] cfg_hgap_i,
    input logic [CNT_W-1:0] cfg_vgap_i,
    input logic             hsync_o,
    input logic             vsync_o,
    input logic             cfg_err_o,
    input logic [CNT_W-1:0] hgap_o,
    input logic [CNT_W-1:0] vgap_o
);
    logic bad_wr;
    assign bad_wr = cfg_wr_i && !((cfg_hgap_i > CNT_W'(1)) && (cfg_hgap_i < cfg_vgap_i));

    p_hs_after_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hsync_o) |-> $past(!de_i));

    p_vs_after_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vsync_o) |-> $past(!de_i));

    p_de_clears_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
        de_i |=> (!$rose(hsync_o) && !$rose(vsync_o)));

    p_order_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hgap_o > CNT_W'(1)) && (hgap_o < vgap_o));

    p_reject_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bad_wr |=> (cfg_err_o && $stable(hgap_o) && $stable(vgap_o)));

    p_err_has_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err_o |-> $past(bad_wr));

    generate
        if (HS_PULSE > 1) begin : g_hs_wide
            p_hs_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(hsync_o) |=> hsync_o);
        end
        if (VS_PULSE > 1) begin : g_vs_wide
            p_vs_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(vsync_o) |=> vsync_o);
        end
    endgenerate

endmodule

bind de_sync_regen de_sync_regen_chk #(
    .CNT_W    (CNT_W),
    .HS_PULSE (HS_PULSE),
    .VS_PULSE (VS_PULSE)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .de_i       (de_i),
    .cfg_wr_i   (cfg_wr_i),
    .cfg_hgap_i (cfg_hgap_i),
    .cfg_vgap_i (cfg_vgap_i),
    .hsync_o    (hsync_o),
    .vsync_o    (vsync_o),
    .cfg_err_o  (cfg_err_o),
    .hgap_o     (hgap_o),
    .vgap_o     (vgap_o)
);

// File: tb/de_sync_regen_tb.sv
module de_sync_regen_tb_top;
    localparam int CW = 12;
    localparam int HP = 2;
    localparam int VP = 3;
    localparam int MAXC = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          de_i = 1'b1;
    logic          cfg_wr_i = 1'b0;
    logic [CW-1:0] cfg_hgap_i = '0;
    logic [CW-1:0] cfg_vgap_i = '0;
    logic          hsync_o, vsync_o, cfg_err_o;
    logic [CW-1:0] hgap_o, vgap_o;

    always #2 clk = ~clk;

    de_sync_regen #(.CNT_W(CW), .HS_PULSE(HP), .VS_PULSE(VP),
                    .DEF_HGAP(4), .DEF_VGAP(40)) dut_i (
        .clk(clk), .rst_n(rst_n), .de_i(de_i), .cfg_wr_i(cfg_wr_i),
        .cfg_hgap_i(cfg_hgap_i), .cfg_vgap_i(cfg_vgap_i),
        .hsync_o(hsync_o), .vsync_o(vsync_o), .cfg_err_o(cfg_err_o),
        .hgap_o(hgap_o), .vgap_o(vgap_o));

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    // Reference state built from the requirements.
    int m_cnt, m_hrem, m_vrem, m_h, m_v;
    bit m_err;
    int hs_rises, vs_rises;
    bit prev_hs, prev_vs;

    task automatic check(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_cnt = 0; m_hrem = 0; m_vrem = 0; m_h = 4; m_v = 40; m_err = 0;
    endtask

    task automatic model_step(input bit de, input bit wr, input int h, input int v);
        bit fh, fv;
        fh = 0; fv = 0;
        if (de) m_cnt = 0;
        else if (m_cnt != MAXC) begin
            m_cnt = m_cnt + 1;
            fh = (m_cnt == m_h);
            fv = (m_cnt == m_v);
        end
        m_hrem = fh ? HP : ((m_hrem > 0) ? m_hrem - 1 : 0);
        m_vrem = fv ? VP : ((m_vrem > 0) ? m_vrem - 1 : 0);
        m_err = 0;
        if (wr) begin
            if (h > 1 && h < v) begin m_h = h; m_v = v; end
            else m_err = 1;
        end
    endtask

    task automatic cyc(input bit de, input bit wr, input int h, input int v);
        @(negedge clk);
        de_i = de; cfg_wr_i = wr;
        cfg_hgap_i = CW'(h); cfg_vgap_i = CW'(v);
        model_step(de, wr, h, v);
        @(posedge clk); #1;
        check("R1/R5 hsync", int'(hsync_o), int'(m_hrem != 0));
        check("R2/R5 vsync", int'(vsync_o), int'(m_vrem != 0));
        check("R7 err", int'(cfg_err_o), int'(m_err));
        check("R6 hgap", int'(hgap_o), m_h);
        check("R6 vgap", int'(vgap_o), m_v);
        if (hsync_o && !prev_hs) hs_rises++;
        if (vsync_o && !prev_vs) vs_rises++;
        prev_hs = hsync_o; prev_vs = vsync_o;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 7;
        void'($urandom(seed));
        prev_hs = 0; prev_vs = 0;
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        check("R8 reset hsync", int'(hsync_o), 0);
        check("R8 reset vsync", int'(vsync_o), 0);
        check("R8 reset err", int'(cfg_err_o), 0);
        check("R8 reset hgap", int'(hgap_o), 4);
        check("R8 reset vgap", int'(vgap_o), 40);
        @(negedge clk); rst_n = 1'b1;

        // R1: three empties do not fire, the fourth does.
        cyc(1, 0, 0, 0);
        for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0);
        check("R1 no early hsync", int'(hsync_o), 0);
        cyc(0, 0, 0, 0);
        check("R1 hsync at threshold", int'(hsync_o), 1);
        cyc(0, 0, 0, 0);
        check("R5 hsync stretched", int'(hsync_o), 1);
        cyc(0, 0, 0, 0);
        check("R5 hsync ends", int'(hsync_o), 0);

        // R3: DE high splits a gap.
        cyc(1, 0, 0, 0);
        hs_rises = 0;
        for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0);
        cyc(1, 0, 0, 0);
        for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0);
        cyc(1, 0, 0, 0);
        check("R3 split gap never fires", hs_rises, 0);

        // R9: write a larger line threshold on the firing edge.
        for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0);
        cyc(0, 1, 6, 40);
        check("R9 old threshold fires", int'(hsync_o), 1);
        check("R9 new hgap visible", int'(hgap_o), 6);
        cyc(1, 0, 0, 0);

        // R7: rejected writes.
        cyc(1, 1, 1, 40);
        check("R7 hgap of 1 rejected", int'(cfg_err_o), 1);
        cyc(1, 1, 40, 40);
        check("R7 equal rejected", int'(cfg_err_o), 1);
        check("R7 hgap kept", int'(hgap_o), 6);
        cyc(1, 0, 0, 0);
        check("R7 err one cycle", int'(cfg_err_o), 0);

        // R2/R5 overlap: vgap one above hgap.
        cyc(1, 1, 5, 6);
        vs_rises = 0;
        for (int i = 0; i < 6; i++) cyc(0, 0, 0, 0);
        check("R2 vsync at threshold", int'(vsync_o), 1);
        check("R5 hsync still high in overlap", int'(hsync_o), 1);
        cyc(1, 0, 0, 0);
        cyc(1, 0, 0, 0);
        check("R5 vsync third cycle", int'(vsync_o), 1);
        cyc(1, 0, 0, 0);
        check("R5 vsync done", int'(vsync_o), 0);

        // R4: saturation with threshold at ceiling.
        cyc(1, 1, MAXC - 1, MAXC);
        hs_rises = 0; vs_rises = 0;
        for (int i = 0; i < MAXC + 900; i++) cyc(0, 0, 0, 0);
        check("R4 one hsync in long gap", hs_rises, 1);
        check("R4 one vsync in long gap", vs_rises, 1);
        cyc(1, 1, 4, 40);

        // Random traffic with occasional writes, checked against the model.
        for (int i = 0; i < 20000; i++) begin
            bit de, wr;
            int h, v;
            de = ($urandom_range(0, 99) < 70);
            if (!de && $urandom_range(0, 3) == 0) begin
                int len;
                len = $urandom_range(1, 50);
                for (int k = 0; k < len; k++) cyc(0, 0, 0, 0);
            end
            wr = ($urandom_range(0, 99) < 3);
            h = $urandom_range(0, 20);
            v = $urandom_range(0, 45);
            cyc(de, wr, h, v);
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule